// File: doc/BRIEF.md
# Banked External Interrupt Trigger Aggregator

This block gathers peripheral interrupt lines, grouped in banks of 32, and folds them onto one trigger output per hardware thread. Each line has a status bit that holds a pending event, a sense bit that picks edge or level behaviour, an optional enable bit, and a small vector register that names the thread trigger the line drives, or none. Software reaches every register through a plain single-cycle register bus: writes take effect at the clock edge, and read data is a combinational function of the address.

Each trigger output is the OR of every line that is pending, enabled and routed to that thread. Working out which line fired is left to software, which reads the status registers. A write of one to a status bit toggles it. Software can therefore clear an edge event and can also re-raise it later. Writing zero to a vector register detaches the line from all triggers. This serves as a masking fallback when the enable registers are left out at build time.

Top module: `irq_agg`

## Requirements
- R1: After reset every status, sense, enable and vector register reads zero and all trigger outputs are low.
- R2: Register addresses are: status at 0x000+8*b, sense at 0x020+8*b, enable at 0x040+8*b for bank b; the vector of line i in bank b at 0x1000+0x1000*b+4*i, holding its value in the low bits. Read data is valid in the same cycle as the address. Any other address reads zero and ignores writes.
- R3: Line number n belongs to bank n>>5, at bit n&31 of that bank's status, sense and enable words.
- R4: For a line whose sense bit is 0 (edge), a rising input sets its status bit at the next clock edge. The bit then holds its value until software writes a 1 to it, which toggles it. Writing 0 changes nothing.
- R5: When a hardware rising edge and a software toggle hit the same edge-mode bit in the same cycle, the bit ends up set.
- R6: For a line whose sense bit is 1 (level), the status bit copies the input one clock later. A write of 1 to that status bit forces it high for one cycle.
- R7: An enable bit of 1 lets a pending line reach its trigger and 0 blocks it. When the block is built without enable registers, every enable word reads all ones and no line is blocked.
- R8: A vector value v in 1..NUM_THREADS routes the line to trig_o[v-1] only. A value of 0 or above NUM_THREADS routes it nowhere.
- R9: trig_o[t] is the OR of status AND enable over all lines routed to thread t. It is formed without a register from the stored state, so an input edge appears on the trigger one clock later.
- R10: Writing 1 to a cleared edge-mode status bit sets it again and re-raises the trigger it is routed to.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32*NUM_BANKS | Peripheral interrupt lines, line n at bit n |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 16 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i |
| trig_o | output | NUM_THREADS | Per-thread core trigger |

## Verification
A corrupted status bit shows up at once in two places: the status read at the next sample, and a trigger that fires or stays quiet when it should not, with no cycles of delay. A wrong enable or vector value leaves the status word correct but sends the trigger to the wrong thread or to none, so the bench checks the triggers and the status reads together. The edge detector's stored copy of each input shows up only through its effect: a stale copy either misses a rising edge or invents one. The bench therefore drives inputs high, low and high again, and checks the status after every step.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int LINES_PER_BANK = 32;
  localparam int ADDR_W         = 16;
  localparam int DATA_W         = 32;

  typedef enum logic [1:0] {
    KIND_STAT  = 2'd0,
    KIND_SENSE = 2'd1,
    KIND_MASK  = 2'd2,
    KIND_NONE  = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/irq_bank.sv
module irq_bank
  import irq_agg_pkg::*;
#(
  parameter bit HAS_MASK = 1'b1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [LINES_PER_BANK-1:0] irq_i,
  input  logic                      wr_stat_i,
  input  logic                      wr_sense_i,
  input  logic                      wr_mask_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [LINES_PER_BANK-1:0] status_o,
  output logic [LINES_PER_BANK-1:0] sense_o,
  output logic [LINES_PER_BANK-1:0] mask_o,
  output logic [LINES_PER_BANK-1:0] pend_o
);
  logic [LINES_PER_BANK-1:0] in_q, status_q, sense_q;
  logic [LINES_PER_BANK-1:0] rise, wr_ones, edge_nxt, lvl_nxt, status_d;

  always_comb begin
    rise     = irq_i & ~in_q;
    wr_ones  = wr_stat_i ? wdata_i : '0;
    // hardware edge wins over a toggle that would clear
    edge_nxt = rise | (status_q ^ wr_ones);
    lvl_nxt  = irq_i | wr_ones;
    status_d = (sense_q & lvl_nxt) | (~sense_q & edge_nxt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q     <= '0;
      status_q <= '0;
      sense_q  <= '0;
    end else begin
      in_q     <= irq_i;
      status_q <= status_d;
      if (wr_sense_i) sense_q <= wdata_i;
    end
  end

  generate
    if (HAS_MASK) begin : g_mask
      logic [LINES_PER_BANK-1:0] mask_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        mask_q <= '0;
        else if (wr_mask_i) mask_q <= wdata_i;
      end
      assign mask_o = mask_q;
    end else begin : g_nomask
      assign mask_o = '1;
    end
  endgenerate

  assign status_o = status_q;
  assign sense_o  = sense_q;
  assign pend_o   = status_q & mask_o;

  assert_edge_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise) |=> ((status_q & $past(rise)) == $past(rise)));

  assert_edge_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((status_q ^ $past(status_q)) & $past(~sense_q & ~rise & ~wr_ones)) == '0));

  assert_level_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(sense_q & ~irq_i & ~wr_ones)) == '0));
endmodule

// File: rtl/irq_vec_file.sv
module irq_vec_file #(
  parameter int NL    = 128,
  parameter int VEC_W = 3,
  parameter int IDX_W = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [VEC_W-1:0]         wdata_i,
  output logic [VEC_W-1:0]         rdata_o,
  output logic [NL-1:0][VEC_W-1:0] vec_o
);
  logic [NL-1:0][VEC_W-1:0] vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   vec_q <= '0;
    else if (wr_i) vec_q[idx_i] <= wdata_i;
  end

  assign rdata_o = vec_q[idx_i];
  assign vec_o   = vec_q;

  assert_vec_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (vec_q[$past(idx_i)] == $past(wdata_i)));
endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NL          = 128,
  parameter int NUM_THREADS = 4,
  parameter int VEC_W       = 3
) (
  input  logic [NL-1:0]            pend_i,
  input  logic [NL-1:0][VEC_W-1:0] vec_i,
  output logic [NUM_THREADS-1:0]   trig_o
);
  generate
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      always_comb begin
        trig_o[t] = 1'b0;
        for (int l = 0; l < NL; l++)
          if (pend_i[l] && vec_i[l] == VEC_W'(t + 1)) trig_o[t] = 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int NUM_THREADS = 4,
  parameter bit HAS_MASK    = 1'b1
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_BANKS*LINES_PER_BANK-1:0] irq_i,
  input  logic                                wr_en_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [DATA_W-1:0]                   wdata_i,
  output logic [DATA_W-1:0]                   rdata_o,
  output logic [NUM_THREADS-1:0]              trig_o
);
  localparam int NL    = NUM_BANKS * LINES_PER_BANK;
  localparam int VEC_W = $clog2(NUM_THREADS + 1);
  localparam int IDX_W = $clog2(NL);

  reg_kind_e ctl_kind;
  logic [1:0] ctl_bank, vec_bank;
  logic [3:0] page;
  logic ctl_hit, vec_hit;
  logic [6:0] idx_full;
  logic [IDX_W-1:0] vec_idx;

  always_comb begin
    ctl_kind = reg_kind_e'(addr_i[6:5]);
    ctl_bank = addr_i[4:3];
    ctl_hit  = (addr_i[15:7] == '0) && (addr_i[2:0] == '0) &&
               (ctl_kind != KIND_NONE) && ({2'b0, ctl_bank} < 3'(NUM_BANKS));
    page     = addr_i[15:12];
    vec_hit  = (page != 4'd0) && (page <= 4'(NUM_BANKS)) &&
               (addr_i[11:7] == '0) && (addr_i[1:0] == '0);
    vec_bank = addr_i[13:12] - 2'd1;
    idx_full = {vec_bank, addr_i[6:2]};
    vec_idx  = idx_full[IDX_W-1:0];
  end

  logic [NUM_BANKS-1:0][LINES_PER_BANK-1:0] stat_w, sense_w, mask_w, pend_w;
  logic [NL-1:0] pend_all;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic sel;
      assign sel = wr_en_i && ctl_hit && (ctl_bank == 2'(b));
      irq_bank #(.HAS_MASK(HAS_MASK)) u_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .irq_i      (irq_i[b*LINES_PER_BANK +: LINES_PER_BANK]),
        .wr_stat_i  (sel && ctl_kind == KIND_STAT),
        .wr_sense_i (sel && ctl_kind == KIND_SENSE),
        .wr_mask_i  (sel && ctl_kind == KIND_MASK),
        .wdata_i    (wdata_i),
        .status_o   (stat_w[b]),
        .sense_o    (sense_w[b]),
        .mask_o     (mask_w[b]),
        .pend_o     (pend_w[b])
      );
      assign pend_all[b*LINES_PER_BANK +: LINES_PER_BANK] = pend_w[b];
    end
  endgenerate

  logic [NL-1:0][VEC_W-1:0] vec_w;
  logic [VEC_W-1:0] vec_rd;

  irq_vec_file #(.NL(NL), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_vec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_en_i && vec_hit),
    .idx_i   (vec_idx),
    .wdata_i (wdata_i[VEC_W-1:0]),
    .rdata_o (vec_rd),
    .vec_o   (vec_w)
  );

  irq_router #(.NL(NL), .NUM_THREADS(NUM_THREADS), .VEC_W(VEC_W)) u_route (
    .pend_i (pend_all),
    .vec_i  (vec_w),
    .trig_o (trig_o)
  );

  always_comb begin
    rdata_o = '0;
    if (vec_hit) rdata_o = {{(DATA_W-VEC_W){1'b0}}, vec_rd};
    else if (ctl_hit) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (ctl_bank == 2'(b)) begin
          unique case (ctl_kind)
            KIND_STAT:  rdata_o = stat_w[b];
            KIND_SENSE: rdata_o = sense_w[b];
            KIND_MASK:  rdata_o = mask_w[b];
            default:    rdata_o = '0;
          endcase
        end
      end
    end
  end

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_all == '0) |-> (trig_o == '0));

  assert_single_route_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(pend_all) <= 1) |-> $onehot0(trig_o));
endmodule

// File: tb/sim_irq_agg.sv
`timescale 1ns/1ps
module sim_irq_agg;
  localparam int NB = 4;
  localparam int NT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB*32-1:0] irq = '0;
  logic wr_en = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata1;
  logic [NT-1:0] trig, trig1;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_agg #(.NUM_BANKS(NB), .NUM_THREADS(NT), .HAS_MASK(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .trig_o(trig));

  // variant without enable registers (R7)
  irq_agg #(.NUM_BANKS(1), .NUM_THREADS(NT), .HAS_MASK(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq[31:0]), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata1), .trig_o(trig1));

  typedef struct packed {
    logic [1:0]  k;   // 0 write, 1 read-check, 2 drive irq[31:0], 3 trigger-check
    logic [3:0]  r;   // requirement number
    logic [15:0] a;
    logic [31:0] d;
  } op_t;

  localparam int NOPS = 51;
  localparam op_t OPS [NOPS] = '{
    '{2'd0, 4'd8,  16'h100C, 32'h1},    // R8 route line 3 to thread 0
    '{2'd0, 4'd7,  16'h0040, 32'h8},    // R7 enable line 3
    '{2'd1, 4'd2,  16'h100C, 32'h1},    // R2 vector readback
    '{2'd2, 4'd4,  16'h0000, 32'h8},    // R4 rising edge
    '{2'd1, 4'd4,  16'h0000, 32'h8},
    '{2'd3, 4'd9,  16'h0000, 32'h1},    // R9
    '{2'd2, 4'd4,  16'h0000, 32'h0},    // R4 input falls, bit held
    '{2'd1, 4'd4,  16'h0000, 32'h8},
    '{2'd0, 4'd4,  16'h0000, 32'h0},    // R4 write 0 ignored
    '{2'd1, 4'd4,  16'h0000, 32'h8},
    '{2'd0, 4'd4,  16'h0000, 32'h8},    // R4 toggle clears
    '{2'd1, 4'd4,  16'h0000, 32'h0},
    '{2'd3, 4'd9,  16'h0000, 32'h0},
    '{2'd0, 4'd10, 16'h0000, 32'h8},    // R10 retrigger
    '{2'd1, 4'd10, 16'h0000, 32'h8},
    '{2'd3, 4'd10, 16'h0000, 32'h1},
    '{2'd0, 4'd4,  16'h0000, 32'h8},
    '{2'd0, 4'd6,  16'h0020, 32'h10},   // R6 line 4 level
    '{2'd0, 4'd8,  16'h1010, 32'h2},
    '{2'd0, 4'd7,  16'h0040, 32'h18},
    '{2'd2, 4'd6,  16'h0000, 32'h10},
    '{2'd1, 4'd6,  16'h0000, 32'h10},
    '{2'd3, 4'd8,  16'h0000, 32'h2},
    '{2'd2, 4'd6,  16'h0000, 32'h0},    // R6 level follows low
    '{2'd1, 4'd6,  16'h0000, 32'h0},
    '{2'd3, 4'd6,  16'h0000, 32'h0},
    '{2'd0, 4'd6,  16'h0000, 32'h10},   // R6 forced trigger
    '{2'd1, 4'd6,  16'h0000, 32'h10},
    '{2'd3, 4'd6,  16'h0000, 32'h2},
    '{2'd2, 4'd6,  16'h0000, 32'h0},
    '{2'd1, 4'd6,  16'h0000, 32'h0},
    '{2'd2, 4'd6,  16'h0000, 32'h10},
    '{2'd0, 4'd7,  16'h0040, 32'h08},   // R7 block line 4
    '{2'd3, 4'd7,  16'h0000, 32'h0},
    '{2'd1, 4'd7,  16'h0000, 32'h10},
    '{2'd0, 4'd7,  16'h0040, 32'h18},
    '{2'd3, 4'd7,  16'h0000, 32'h2},
    '{2'd0, 4'd8,  16'h1010, 32'h0},    // R8 unrouted
    '{2'd3, 4'd8,  16'h0000, 32'h0},
    '{2'd0, 4'd8,  16'h1010, 32'h5},    // R8 out of range
    '{2'd3, 4'd8,  16'h0000, 32'h0},
    '{2'd0, 4'd8,  16'h1010, 32'h4},
    '{2'd3, 4'd8,  16'h0000, 32'h8},
    '{2'd1, 4'd2,  16'h1010, 32'h4},
    '{2'd2, 4'd9,  16'h0000, 32'h0},
    '{2'd3, 4'd9,  16'h0000, 32'h0},
    '{2'd1, 4'd2,  16'h0060, 32'h0},    // R2 unmapped
    '{2'd0, 4'd2,  16'h0060, 32'hFFFFFFFF},
    '{2'd1, 4'd2,  16'h0000, 32'h0},
    '{2'd1, 4'd2,  16'h0040, 32'h18},
    '{2'd1, 4'd2,  16'h0020, 32'h10}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [15:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 status", 16'h0000, 32'h0);
    rd_chk("R1 sense",  16'h0020, 32'h0);
    rd_chk("R1 enable", 16'h0040, 32'h0);
    rd_chk("R1 vector", 16'h4000, 32'h0);
    #1 check("R1 trig", 32'(trig), 32'h0);

    for (int i = 0; i < NOPS; i++) begin
      string tag;
      tag = $sformatf("R%0d step %0d", OPS[i].r, i);
      case (OPS[i].k)
        2'd0: reg_wr(OPS[i].a, OPS[i].d);
        2'd1: rd_chk(tag, OPS[i].a, OPS[i].d);
        2'd2: begin irq[31:0] = OPS[i].d; step(); end
        default: begin #1; check(tag, 32'(trig), OPS[i].d); end
      endcase
    end

    // R7 no-enable variant passes a line that u0 blocks
    reg_wr(16'h0040, 32'h0);
    reg_wr(16'h1000, 32'h1);
    irq[31:0] = 32'h1; step();
    #1;
    check("R7 blocked trig", 32'(trig), 32'h0);
    check("R7 no-enable trig", 32'(trig1), 32'h1);
    addr = 16'h0040; #1;
    check("R7 no-enable reads ones", rdata1, 32'hFFFFFFFF);

    // R5 edge and toggle in the same cycle
    reg_wr(16'h0040, 32'h8);
    irq[31:0] = 32'h9; step();
    irq[31:0] = 32'h1; step();
    irq[31:0] = 32'h9;
    reg_wr(16'h0000, 32'h8);
    rd_chk("R5 edge beats toggle", 16'h0000, 32'h9);
    reg_wr(16'h0000, 32'h8);
    rd_chk("R4 toggle with input high", 16'h0000, 32'h1);

    // R3 line 100 -> bank 3 bit 4
    reg_wr(16'h4010, 32'h3);
    reg_wr(16'h0058, 32'h10);
    irq[100] = 1'b1; step();
    rd_chk("R3 bank3 status", 16'h0018, 32'h10);
    #1 check("R3 trig thread2", 32'(trig), 32'h4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule